// File: doc/BRIEF.md
# Adaptive Sine-Fit Self-Test Datapath

This block is the processing core of an on-chip converter self-test. While a test stimulus drives the converter with a sine, the block gathers the converter's 16-bit signed output samples. It then fits a digital reference sine, produced by an external CORDIC unit, to those samples. Last, it accumulates how far the samples stray from the fitted reference. The fit uses only adders, comparators and fixed shifts, so it needs no multiplier or divider of its own. The one division it needs is handed to the CORDIC unit running in its division mode.

After a `start` pulse the block steps through four phases. First it estimates the DC level by summing a full record of samples and dividing by the record length. Second, it learns the amplitude by nudging the CORDIC start value up or down after each sample. Third, it sums absolute fitting errors over a new record. Finally it streams a serial signature: the fitted start value, then the error sum. Outside logic turns these two numbers into a noise figure.

Top module: `sfit_bist_core`

## Requirements
- R1: After reset the block is idle. `done`, `cor_req` and `sig_bit` are 0, and the block does nothing until `start` is seen high.
- R2: The offset phase adds exactly 563 valid samples (one per cycle with `smp_valid` high) into a 21-bit accumulator. It then issues one request with `cor_mode` = 1 and `cor_xin` equal to that sum. The 16-bit answer on `cor_result` is stored as the offset.
- R3: The 21-bit accumulator saturates at -1048576 and +1048575 instead of wrapping, both in the offset sum and in the error sum.
- R4: In the fitting phases each accepted sample is latched on a `smp_valid` cycle and then answered by one request with `cor_mode` = 0 and `cor_xin` equal to the current start value, sign-extended. While that request is pending, `smp_valid` is ignored. There are 281 + 563 = 844 such requests per run.
- R5: Amplitude update: d = sample − (reference + offset). d is negated when bit 15 of the reference (`cor_result`) is 1. The start value then moves by d arithmetically shifted right by 5 (floor), saturating at −32768 and +32767. The start value is 4096 at each `start`.
- R6: The amplitude phase makes exactly 281 updates (32 of the 64 stimulus periods in a 563-sample record) before error summing begins.
- R7: The error phase adds |reference + offset − sample| for 563 samples, with the start value held fixed.
- R8: The signature leaves on `sig_bit`, MSB first. The 16-bit start value comes first, then the 21-bit error sum, with no gap between them. `sig_bit` shows the current bit, and the next bit appears after each clock edge with `shift_en` high. Edges with `shift_en` low leave the bit unchanged.
- R9: `done` rises after the 37th bit has been shifted out and stays high until the next `start`. `start` has no effect while a run is in progress.
- R10: `cor_req` is a one-cycle pulse. No new request is issued until `cor_ready` has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run from idle or done |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 16 | Converter sample, two's complement |
| cor_req | output | 1 | Request pulse to the CORDIC unit |
| cor_mode | output | 1 | 1 = divide the operand by the record length, 0 = sine |
| cor_xin | output | 21 | CORDIC operand: sum to divide, or sign-extended start value |
| cor_ready | input | 1 | CORDIC answer strobe |
| cor_result | input | 16 | CORDIC answer: quotient or reference sample |
| shift_en | input | 1 | Advance the signature by one bit |
| sig_bit | output | 1 | Current signature bit |
| done | output | 1 | Signature fully shifted out |

## Verification
The assertions assume that the CORDIC unit answers each request exactly once with a single `cor_ready` pulse and never answers unasked. They also assume that `start` is the only event that ends the done state. The bench's CORDIC stand-in replies a fixed number of cycles after each pulse and only then. The sample stream is spaced so that every intended sample lands while the block waits for one. Extra strobes and a stray `start` are added on purpose, and they fall only inside request windows, where the requirements say they must be ignored.

// File: rtl/sfit_pkg.sv
// Shared types for the sine-fit self-test datapath.
// Assumes: one controller drives one datapath; no other user of these types.
package sfit_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OFS,
        PH_DIV,
        PH_AMP,
        PH_ERR,
        PH_SIGX,
        PH_SIGE,
        PH_DONE
    } sfit_phase_e;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_REQ,
        ST_RESP
    } sfit_step_e;

    // One-cycle strobes from the controller to the datapath and shifter.
    typedef struct packed {
        logic acc_clr;
        logic acc_ofs;
        logic acc_err;
        logic take;
        logic off_ld;
        logic x0_init;
        logic x0_upd;
        logic sig_ldx;
        logic sig_lde;
        logic sig_sh;
    } sfit_ctl_t;

endpackage

// File: rtl/sfit_seq.sv
// Phase sequencer: offset sum, division, amplitude learning, error sum,
// signature shift. Issues CORDIC requests one at a time and waits for ready.
// Assumes: cor_ready answers each request exactly once.
module sfit_seq
    import sfit_pkg::*;
#(
    parameter int SMP_REC = 563,
    parameter int AMP_N   = 281,
    parameter int X_W     = 16,
    parameter int ACC_W   = 21
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      smp_valid,
    input  logic      cor_ready,
    input  logic      shift_en,
    output logic      cor_req,
    output logic      cor_mode,
    output logic      done,
    output sfit_ctl_t ctl
);

    localparam int CNT_W = $clog2(SMP_REC + 1);
    localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(SMP_REC - 1);
    localparam logic [CNT_W-1:0] AMP_LAST = CNT_W'(AMP_N - 1);
    localparam logic [CNT_W-1:0] X_LAST   = CNT_W'(X_W - 1);
    localparam logic [CNT_W-1:0] A_LAST   = CNT_W'(ACC_W - 1);

    sfit_phase_e      phase;
    sfit_step_e       step;
    logic [CNT_W-1:0] cnt;

    logic             launch;
    logic             fit_ph;
    logic             fit_last;
    logic             got_ref;

    // Derived conditions shared by the state update and the strobes.
    always_comb begin
        launch   = ((phase == PH_IDLE) || (phase == PH_DONE)) && start;
        fit_ph   = (phase == PH_AMP) || (phase == PH_ERR);
        fit_last = (phase == PH_AMP) ? (cnt == AMP_LAST) : (cnt == REC_LAST);
        got_ref  = (step == ST_RESP) && cor_ready;
    end

    // Phase, handshake step and sample/bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= ST_WAIT;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        phase <= PH_OFS;
                        step  <= ST_WAIT;
                        cnt   <= '0;
                    end
                end
                PH_OFS: begin
                    if (smp_valid) begin
                        if (cnt == REC_LAST) begin
                            phase <= PH_DIV;
                            step  <= ST_REQ;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DIV: begin
                    if (step == ST_REQ) begin
                        step <= ST_RESP;
                    end else if (got_ref) begin
                        phase <= PH_AMP;
                        step  <= ST_WAIT;
                    end
                end
                PH_AMP, PH_ERR: begin
                    case (step)
                        ST_WAIT: if (smp_valid) step <= ST_REQ;
                        ST_REQ:  step <= ST_RESP;
                        ST_RESP: begin
                            if (cor_ready) begin
                                step <= ST_WAIT;
                                if (fit_last) begin
                                    cnt   <= '0;
                                    phase <= (phase == PH_AMP) ? PH_ERR : PH_SIGX;
                                end else begin
                                    cnt <= cnt + 1'b1;
                                end
                            end
                        end
                        default: step <= ST_WAIT;
                    endcase
                end
                PH_SIGX: begin
                    if (shift_en) begin
                        if (cnt == X_LAST) begin
                            phase <= PH_SIGE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_SIGE: begin
                    if (shift_en) begin
                        if (cnt == A_LAST) begin
                            phase <= PH_DONE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Request, mode, done and datapath strobes.
    always_comb begin
        cor_req      = ((phase == PH_DIV) || fit_ph) && (step == ST_REQ);
        cor_mode     = (phase == PH_DIV);
        done         = (phase == PH_DONE);
        ctl          = '0;
        ctl.x0_init  = launch;
        ctl.acc_clr  = launch || ((phase == PH_DIV) && got_ref);
        ctl.off_ld   = (phase == PH_DIV) && got_ref;
        ctl.acc_ofs  = (phase == PH_OFS) && smp_valid;
        ctl.take     = fit_ph && (step == ST_WAIT) && smp_valid;
        ctl.x0_upd   = (phase == PH_AMP) && got_ref;
        ctl.acc_err  = (phase == PH_ERR) && got_ref;
        ctl.sig_ldx  = (phase == PH_ERR) && got_ref && fit_last;
        ctl.sig_lde  = (phase == PH_SIGX) && shift_en && (cnt == X_LAST);
        ctl.sig_sh   = ((phase == PH_SIGX) && shift_en && (cnt != X_LAST)) ||
                       ((phase == PH_SIGE) && shift_en);
    end

endmodule

// File: rtl/sfit_dp.sv
// Arithmetic datapath: sample latch, offset register, CORDIC start value
// with shift-only learning update, and the wide saturating accumulator.
// Assumes: strobes from sfit_seq; cor_result valid in the cycle cor_ready is high.
module sfit_dp
    import sfit_pkg::*;
#(
    parameter int X_W     = 16,
    parameter int ACC_W   = 21,
    parameter int LRN_SH  = 5,
    parameter int X0_INIT = 4096
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  sfit_ctl_t               ctl,
    input  logic signed [X_W-1:0]   smp_data,
    input  logic signed [X_W-1:0]   cor_result,
    output logic signed [X_W-1:0]   x0_q,
    output logic signed [ACC_W-1:0] acc_q
);

    localparam int D_W = X_W + 2;
    localparam logic signed [D_W:0]   X_HI = (D_W+1)'((2 ** (X_W - 1)) - 1);
    localparam logic signed [D_W:0]   X_LO = -(D_W+1)'(2 ** (X_W - 1));
    localparam logic signed [ACC_W:0] A_HI = (ACC_W+1)'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [ACC_W:0] A_LO = -(ACC_W+1)'(2 ** (ACC_W - 1));

    logic signed [X_W-1:0]   smp_q;
    logic signed [X_W-1:0]   off_q;
    logic signed [D_W-1:0]   ref_c;
    logic signed [D_W-1:0]   diff;
    logic signed [D_W-1:0]   dsg;
    logic signed [D_W-1:0]   absd;
    logic signed [D_W-1:0]   lstep;
    logic signed [D_W:0]     x0_sum;
    logic signed [X_W-1:0]   x0_nxt;
    logic signed [ACC_W-1:0] acc_in;
    logic signed [ACC_W:0]   acc_sum;
    logic signed [ACC_W-1:0] acc_nxt;

    // Fitting error and learning step from the latched sample.
    always_comb begin
        ref_c  = D_W'(cor_result) + D_W'(off_q);
        diff   = D_W'(smp_q) - ref_c;
        dsg    = cor_result[X_W-1] ? -diff : diff;
        absd   = diff[D_W-1] ? -diff : diff;
        lstep  = dsg >>> LRN_SH;
        x0_sum = (D_W+1)'(x0_q) + (D_W+1)'(lstep);
        if (x0_sum > X_HI)      x0_nxt = X_W'(X_HI);
        else if (x0_sum < X_LO) x0_nxt = X_W'(X_LO);
        else                    x0_nxt = X_W'(x0_sum);
    end

    // Saturating accumulate of a raw sample or an absolute error.
    always_comb begin
        acc_in  = ctl.acc_ofs ? ACC_W'(smp_data) : ACC_W'(absd);
        acc_sum = (ACC_W+1)'(acc_q) + (ACC_W+1)'(acc_in);
        if (acc_sum > A_HI)      acc_nxt = ACC_W'(A_HI);
        else if (acc_sum < A_LO) acc_nxt = ACC_W'(A_LO);
        else                     acc_nxt = ACC_W'(acc_sum);
    end

    // Register updates selected by controller strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= '0;
            off_q <= '0;
            x0_q  <= X_W'(X0_INIT);
            acc_q <= '0;
        end else begin
            if (ctl.take)    smp_q <= smp_data;
            if (ctl.off_ld)  off_q <= cor_result;
            if (ctl.x0_init)     x0_q <= X_W'(X0_INIT);
            else if (ctl.x0_upd) x0_q <= x0_nxt;
            if (ctl.acc_clr) acc_q <= '0;
            else if (ctl.acc_ofs || ctl.acc_err) acc_q <= acc_nxt;
        end
    end

endmodule

// File: rtl/sfit_sig.sv
// Signature shifter: loads the start value left-aligned, then the error sum,
// and presents its MSB as the serial output.
// Assumes: load and shift strobes are mutually exclusive per cycle.
module sfit_sig
    import sfit_pkg::*;
#(
    parameter int X_W   = 16,
    parameter int ACC_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sfit_ctl_t        ctl,
    input  logic [X_W-1:0]   x0_q,
    input  logic [ACC_W-1:0] acc_q,
    output logic             sig_bit
);

    logic [ACC_W-1:0] shreg;

    // Load or advance the serial signature register.
    always_ff @(posedge clk) begin
        if (!rst_n)           shreg <= '0;
        else if (ctl.sig_ldx) shreg <= {x0_q, {(ACC_W - X_W){1'b0}}};
        else if (ctl.sig_lde) shreg <= acc_q;
        else if (ctl.sig_sh)  shreg <= {shreg[ACC_W-2:0], 1'b0};
    end

    assign sig_bit = shreg[ACC_W-1];

endmodule

// File: rtl/sfit_bist_core.sv
// Top of the sine-fit self-test datapath: sequencer, arithmetic and shifter.
// Assumes: an external CORDIC unit answers each cor_req with one cor_ready.
module sfit_bist_core
    import sfit_pkg::*;
#(
    parameter int X_W         = 16,
    parameter int ACC_GUARD   = 5,
    parameter int SMP_REC     = 563,
    parameter int REC_PERIODS = 64,
    parameter int AMP_PERIODS = 32,
    parameter int LRN_SH      = 5,
    parameter int X0_INIT     = 4096,
    localparam int ACC_W      = X_W + ACC_GUARD,
    localparam int AMP_N      = SMP_REC * AMP_PERIODS / REC_PERIODS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [X_W-1:0]   smp_data,
    output logic             cor_req,
    output logic             cor_mode,
    output logic [ACC_W-1:0] cor_xin,
    input  logic             cor_ready,
    input  logic [X_W-1:0]   cor_result,
    input  logic             shift_en,
    output logic             sig_bit,
    output logic             done
);

    sfit_ctl_t               ctl;
    logic signed [X_W-1:0]   x0_q;
    logic signed [ACC_W-1:0] acc_q;

    sfit_seq #(
        .SMP_REC (SMP_REC),
        .AMP_N   (AMP_N),
        .X_W     (X_W),
        .ACC_W   (ACC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .smp_valid (smp_valid),
        .cor_ready (cor_ready),
        .shift_en  (shift_en),
        .cor_req   (cor_req),
        .cor_mode  (cor_mode),
        .done      (done),
        .ctl       (ctl)
    );

    sfit_dp #(
        .X_W     (X_W),
        .ACC_W   (ACC_W),
        .LRN_SH  (LRN_SH),
        .X0_INIT (X0_INIT)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .smp_data   (smp_data),
        .cor_result (cor_result),
        .x0_q       (x0_q),
        .acc_q      (acc_q)
    );

    sfit_sig #(
        .X_W   (X_W),
        .ACC_W (ACC_W)
    ) u_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .x0_q    (x0_q),
        .acc_q   (acc_q),
        .sig_bit (sig_bit)
    );

    // Operand to the CORDIC: record sum for division, else start value.
    assign cor_xin = cor_mode ? acc_q : ACC_W'(x0_q);

endmodule

// File: rtl/sfit_bist_chk.sv
// Protocol checker for sfit_bist_core, attached by bind.
// Assumes: cor_ready answers requests only; start is the only exit from done.
module sfit_bist_chk #(
    parameter int X_W   = 16,
    parameter int ACC_W = 21,
    parameter int AMP_N = 281
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cor_req,
    input logic             cor_mode,
    input logic             cor_ready,
    input logic [ACC_W-1:0] cor_xin,
    input logic             done
);

    logic             pend;
    int unsigned      nsin;
    logic [ACC_W-1:0] last_xin;

    // Track the outstanding request and sine requests of the current run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            nsin     <= 0;
            last_xin <= '0;
        end else begin
            if (cor_req)        pend <= 1'b1;
            else if (cor_ready) pend <= 1'b0;
            if (done) begin
                nsin <= 0;
            end else if (cor_req && !cor_mode) begin
                nsin     <= nsin + 1;
                last_xin <= cor_xin;
            end
        end
    end

    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cor_req |=> !cor_req);

    assert_one_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> !cor_req);

    assert_sext_operand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_req && !cor_mode) |->
            ((&cor_xin[ACC_W-1:X_W-1]) || !(|cor_xin[ACC_W-1:X_W-1])));

    assert_x0_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cor_req && !cor_mode && (nsin > AMP_N)) |-> (cor_xin == last_xin));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_no_req_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cor_req);

endmodule

bind sfit_bist_core sfit_bist_chk #(
    .X_W   (X_W),
    .ACC_W (ACC_W),
    .AMP_N (AMP_N)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cor_req   (cor_req),
    .cor_mode  (cor_mode),
    .cor_ready (cor_ready),
    .cor_xin   (cor_xin),
    .done      (done)
);

// File: tb/sfit_bist_core_bench.sv
module sfit_bist_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int REC   = 563;
    localparam int AMPN  = 281;
    localparam int NSIN  = AMPN + REC;
    localparam int TOT   = REC + NSIN;
    localparam int AW    = 21;
    localparam int XINIT = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          smp_valid = 1'b0;
    logic [15:0]   smp_data = '0;
    logic          cor_req;
    logic          cor_mode;
    logic [AW-1:0] cor_xin;
    logic          cor_ready = 1'b0;
    logic [15:0]   cor_result = '0;
    logic          shift_en = 1'b0;
    logic          sig_bit;
    logic          done;

    sfit_bist_core u_sfit_bist_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .cor_req    (cor_req),
        .cor_mode   (cor_mode),
        .cor_xin    (cor_xin),
        .cor_ready  (cor_ready),
        .cor_result (cor_result),
        .shift_en   (shift_en),
        .sig_bit    (sig_bit),
        .done       (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int smp_a [TOT];
    int x0_seq [NSIN];
    int m_sum, m_off, m_x0, m_err;

    function automatic int clampi(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int ref_of(int x0, int k);
        real v;
        v = x0 * 1.6468 * $sin(6.283185307179586 * 64.0 * k / 563.0);
        return clampi($rtoi(v), -32768, 32767);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural CORDIC stand-in: replies two cycles after each request.
    logic        sb_clr = 1'b0;
    int          sin_k, xin_bad, div_xin, dly;
    logic [15:0] pend_res;
    always @(posedge clk) begin
        cor_ready <= 1'b0;
        if (dly == 1) begin
            cor_ready  <= 1'b1;
            cor_result <= pend_res;
        end
        if (dly > 0) dly <= dly - 1;
        if (sb_clr) begin
            sin_k   <= 0;
            xin_bad <= 0;
            div_xin <= 0;
            dly     <= 0;
        end else if (cor_req) begin
            if (cor_mode) begin
                div_xin  <= $signed(cor_xin);
                pend_res <= 16'($signed(cor_xin) / 563);
            end else begin
                if (sin_k >= NSIN || $signed(cor_xin) != x0_seq[sin_k])
                    xin_bad <= xin_bad + 1;
                pend_res <= 16'(ref_of($signed(cor_xin), sin_k));
                sin_k    <= sin_k + 1;
            end
            dly <= 2;
        end
    end

    // Build stimulus and the expected signature from the requirements.
    task automatic build(int amp, int ofs, int noise, bit cst);
        int x0, acc, r, d;
        for (int s = 0; s < TOT; s++) begin
            if (cst) smp_a[s] = ofs;
            else smp_a[s] = clampi($rtoi(amp * $sin(6.283185307179586 * 64.0 * s / 563.0))
                                   + ofs + $signed($urandom_range(2 * noise)) - noise,
                                   -32768, 32767);
        end
        acc = 0;
        for (int s = 0; s < REC; s++) acc = clampi(acc + smp_a[s], -1048576, 1048575);
        m_sum = acc;
        m_off = m_sum / 563;
        x0 = XINIT;
        for (int k = 0; k < AMPN; k++) begin   // R5, R6
            x0_seq[k] = x0;
            r = ref_of(x0, k);
            d = smp_a[REC + k] - (r + m_off);
            if (r < 0) d = -d;
            x0 = clampi(x0 + (d >>> 5), -32768, 32767);
        end
        m_x0 = x0;
        acc = 0;
        for (int k = AMPN; k < NSIN; k++) begin  // R7, R3
            x0_seq[k] = x0;
            r = ref_of(x0, k);
            d = r + m_off - smp_a[REC + k];
            if (d < 0) d = -d;
            acc = clampi(acc + d, -1048576, 1048575);
        end
        m_err = acc;
    endtask

    task automatic run(string tag, int amp, int ofs, int noise, bit cst);
        logic [15:0] got_x;
        logic [AW-1:0] got_e;
        build(amp, ofs, noise, cst);
        @(negedge clk); sb_clr = 1'b1;
        @(negedge clk); sb_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int s = 0; s < TOT; s++) begin
            smp_valid = 1'b1;
            smp_data  = 16'(smp_a[s]);
            for (int j = 1; j < 8; j++) begin
                @(negedge clk);
                // R4: extra strobe while the request is pending is ignored.
                smp_valid = (s >= REC) && (s % 3 == 0) && (j == 2);
                if (j == 2) smp_data = 16'($urandom);
                // R9: stray start mid-run is ignored.
                start = (s == 700) && (j == 4);
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        repeat (12) @(negedge clk);
        check(div_xin == m_sum, {tag, " R2 R3 division operand"}, div_xin, m_sum);
        check(xin_bad == 0, {tag, " R5 R6 start value per request"}, xin_bad, 0);
        check(sin_k == NSIN, {tag, " R4 sine request count"}, sin_k, NSIN);
        check(done == 1'b0, {tag, " R9 done before shift"}, int'(done), 0);
        got_x = '0;
        got_e = '0;
        for (int i = 0; i < 16 + AW; i++) begin
            if ($urandom_range(3) == 0) begin
                shift_en = 1'b0;
                @(negedge clk);
            end
            shift_en = 1'b1;
            if (i < 16) got_x = {got_x[14:0], sig_bit};
            else        got_e = {got_e[AW-2:0], sig_bit};
            if (i == 16 + AW - 1)
                check(done == 1'b0, {tag, " R9 done before last bit"}, int'(done), 0);
            @(negedge clk);
        end
        shift_en = 1'b0;
        check(got_x == 16'(m_x0), {tag, " R8 R5 signature start value"},
              int'($signed(got_x)), m_x0);
        check(got_e == AW'(m_err), {tag, " R8 R7 signature error sum"},
              int'($signed(got_e)), m_err);
        check(done == 1'b1, {tag, " R9 done after last bit"}, int'(done), 1);
        repeat (3) @(negedge clk);
        check(done == 1'b1, {tag, " R9 done held"}, int'(done), 1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(done == 1'b0, "R1 done idle", int'(done), 0);
        check(cor_req == 1'b0, "R1 no request idle", int'(cor_req), 0);
        check(sig_bit == 1'b0, "R1 sig_bit idle", int'(sig_bit), 0);
        run("nominal", 8000, 150, 20, 1'b0);
        run("random", $urandom_range(14000, 6000), -$signed($urandom_range(600)),
            $urandom_range(300, 50), 1'b0);
        run("saturate", 0, -32768, 0, 1'b1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule